// File: doc/BRIEF.md
# Dual-Mode Display PHY Clock Enable Tree

This block produces the byte-rate and pixel-rate clock enables for a display serial PHY. It runs from one fast clock, which stands in for the PLL output. Every divided clock is a one-cycle enable pulse in that domain, not a gated clock. A four-entry register interface holds the following:

- the global control byte, which carries the mode bit;
- the pixel-source select;
- the bit divider;
- the pixel divider.

In D-PHY mode the byte enable is one eighth of the bit-source rate. The pixel source is picked from three inputs: the bit source, the bit source halved, or the PLL rate quartered.

In C-PHY mode the block switches to a parallel path. The byte enable is one seventh of the bit-source rate. The pixel source is a fractional divide-by-3.5 of the PLL rate, and the effective select is held at 3 whatever software writes. The control-mode code is 0x00 in C-PHY mode and 0x10 in D-PHY mode. A misconfiguration flag reports a select value that does not match the current mode. Divider updates are deferred to the next terminal count, so no enable period is ever cut short.

Top module: `clk_div_tree`

## Requirements
- R1: A synchronous active-high reset selects D-PHY mode and loads both dividers with 1. It also clears the select to 0 and clears every counter. After reset, bitEn and pixEn pulse every cycle, byteEn pulses every 8 cycles, ctrlModeCode is 0x10, misCfg is 0, and register 2 reads back 1.
- R2: Bit 6 of register 0 (address 0) sets the mode: 1 selects C-PHY and 0 selects D-PHY. The mode is visible on phyModeC one cycle after the write. ctrlModeCode is 0x00 in C-PHY mode and 0x10 in D-PHY mode.
- R3: The bit divider sits at register 2, bits [3:0]. bitEn pulses once every N cycles for N = 1 to 15, and a written value of 0 acts as 1.
- R4: byteEn pulses once per 8 bitEn pulses in D-PHY mode and once per 7 in C-PHY mode. It is always coincident with a bitEn pulse.
- R5: The pixel-source select sits at register 1, bits [1:0]. In D-PHY mode it picks the pixel source: select 0 is bitEn, select 1 is bitEn divided by 2, and select 2 is the clock divided by 4. The chosen source is then divided by the pixel divider.
- R6: In C-PHY mode, register 1 reads back select 3 whatever was written. pixEn then comes from the divide-by-3.5 source divided by the pixel divider. That source repeats every 7 cycles with two pulses spaced 3 and 4 cycles apart.
- R7: misCfg is 1 in two cases: C-PHY mode with a stored select other than 3, or D-PHY mode with a stored select of 3. The flag follows the register state one cycle after the write that causes it, and the write itself is still accepted.
- R8: A divider written mid-period takes effect only after the current period completes. For example, a bit divider changed from 5 to 2 gives one more gap of 5 cycles, then gaps of 2.
- R9: The pixel divider sits at register 3, bits [3:0]. It divides by N for N = 1 to 15, and a written value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, stands in for the PLL output |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 global, 1 select, 2 bit divider, 3 pixel divider |
| wrData | input | 8 | Write data |
| rdAddr | input | 2 | Read address |
| rdData | output | 8 | Read data; address 1 returns the effective select |
| bitEn | output | 1 | Bit-source enable pulse |
| byteEn | output | 1 | Byte-rate enable pulse |
| pixEn | output | 1 | Pixel-rate enable pulse |
| phyModeC | output | 1 | 1 when in C-PHY mode |
| ctrlModeCode | output | 8 | Control-mode code: 0x00 in C-PHY mode, 0x10 in D-PHY mode |
| misCfg | output | 1 | Select does not match the mode |

## Verification
A register write can land on the same clock edge at which a divider reaches terminal count and reloads its ratio. The reload must take the old ratio, so the period in progress completes unchanged. The bench provokes this by waiting for a bitEn pulse with the divider at 5 and issuing a write of 2 at once, so the register update and the reload share one edge. It then requires a gap of 5 followed by a gap of 2. A select write in C-PHY mode falls in the same cycle as the running 3.5 pattern. The bench judges that the pixel rate stays at 20 pulses per 70 cycles while the flag rises.

// File: rtl/clk_tree_pkg.sv
package clk_tree_pkg;
  localparam int DIV_W     = 4;
  localparam int SEL_W     = 2;
  localparam int ADDR_W    = 2;
  localparam int DATA_W    = 8;
  localparam int MODE_BIT  = 6;
  localparam int BYTE_D    = 8;
  localparam int BYTE_C    = 7;
  localparam int POSTBIT   = 2;
  localparam int PLLQUART  = 4;
  localparam int FRAC_LEN  = 7;
  localparam int FRAC_P0   = 2;
  localparam int FRAC_P1   = 6;
  localparam int FRAC_W    = $clog2(FRAC_LEN);
  localparam logic [SEL_W-1:0]  SEL_CPHY = '1;
  localparam logic [DATA_W-1:0] CODE_C   = 8'h00;
  localparam logic [DATA_W-1:0] CODE_D   = 8'h10;

  typedef struct packed {
    logic             cphy;
    logic [SEL_W-1:0] pixSel;
    logic [DIV_W-1:0] bitRatio;
    logic [DIV_W-1:0] pixRatio;
    logic [DIV_W-1:0] byteRatio;
  } tree_ctl_t;
endpackage

// File: rtl/div_stage.sv
module div_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] ratio,
  output logic         tick
);
  logic [W-1:0] cnt;
  logic [W-1:0] cur;

  assign tick = ce && (cnt == cur - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      cur <= W'(1);
    end else if (ce) begin
      if (tick) begin
        cnt <= '0;
        cur <= ratio;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/frac_stage.sv
module frac_stage
  import clk_tree_pkg::*;
(
  input  logic clk,
  input  logic rst,
  output logic tick
);
  logic [FRAC_W-1:0] phase;

  assign tick = (phase == FRAC_W'(FRAC_P0)) || (phase == FRAC_W'(FRAC_P1));

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else if (phase == FRAC_W'(FRAC_LEN - 1)) phase <= '0;
    else phase <= phase + 1'b1;
  end
endmodule

// File: rtl/clk_tree_ctrl.sv
module clk_tree_ctrl
  import clk_tree_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output tree_ctl_t         ctl,
  output logic [DATA_W-1:0] ctrlModeCode,
  output logic              misCfg
);
  logic [DATA_W-1:0] glblReg;
  logic [SEL_W-1:0]  selReg;
  logic [DIV_W-1:0]  bitReg;
  logic [DIV_W-1:0]  pixReg;
  logic              cphy;
  logic [SEL_W-1:0]  effSel;

  always_ff @(posedge clk) begin
    if (rst) begin
      glblReg <= '0;
      selReg  <= '0;
      bitReg  <= DIV_W'(1);
      pixReg  <= DIV_W'(1);
    end else if (wrEn) begin
      case (wrAddr)
        2'd0:    glblReg <= wrData;
        2'd1:    selReg  <= wrData[SEL_W-1:0];
        2'd2:    bitReg  <= wrData[DIV_W-1:0];
        default: pixReg  <= wrData[DIV_W-1:0];
      endcase
    end
  end

  assign cphy   = glblReg[MODE_BIT];
  assign effSel = cphy ? SEL_CPHY : selReg;
  assign misCfg = cphy ? (selReg != SEL_CPHY) : (selReg == SEL_CPHY);
  assign ctrlModeCode = cphy ? CODE_C : CODE_D;

  always_comb begin
    ctl.cphy      = cphy;
    ctl.pixSel    = effSel;
    ctl.bitRatio  = (bitReg == '0) ? DIV_W'(1) : bitReg;
    ctl.pixRatio  = (pixReg == '0) ? DIV_W'(1) : pixReg;
    ctl.byteRatio = cphy ? DIV_W'(BYTE_C) : DIV_W'(BYTE_D);
  end

  always_comb begin
    case (rdAddr)
      2'd0:    rdData = glblReg;
      2'd1:    rdData = DATA_W'(effSel);
      2'd2:    rdData = DATA_W'(bitReg);
      default: rdData = DATA_W'(pixReg);
    endcase
  end
endmodule

// File: rtl/clk_tree_dp.sv
module clk_tree_dp
  import clk_tree_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  tree_ctl_t ctl,
  output logic      bitEn,
  output logic      byteEn,
  output logic      pixEn,
  output logic      frac35En
);
  logic postBitEn;
  logic quartEn;
  logic dSrcEn;
  logic dPixEn;
  logic cPixEn;

  div_stage #(.W(DIV_W)) u_bit (
    .clk(clk), .rst(rst), .ce(1'b1), .ratio(ctl.bitRatio), .tick(bitEn)
  );

  div_stage #(.W(DIV_W)) u_byte (
    .clk(clk), .rst(rst), .ce(bitEn), .ratio(ctl.byteRatio), .tick(byteEn)
  );

  div_stage #(.W(DIV_W)) u_postbit (
    .clk(clk), .rst(rst), .ce(bitEn), .ratio(DIV_W'(POSTBIT)), .tick(postBitEn)
  );

  div_stage #(.W(DIV_W)) u_quart (
    .clk(clk), .rst(rst), .ce(1'b1), .ratio(DIV_W'(PLLQUART)), .tick(quartEn)
  );

  frac_stage u_frac (
    .clk(clk), .rst(rst), .tick(frac35En)
  );

  always_comb begin
    case (ctl.pixSel)
      2'd0:    dSrcEn = bitEn;
      2'd1:    dSrcEn = postBitEn;
      2'd2:    dSrcEn = quartEn;
      default: dSrcEn = frac35En;
    endcase
  end

  div_stage #(.W(DIV_W)) u_dpix (
    .clk(clk), .rst(rst), .ce(dSrcEn), .ratio(ctl.pixRatio), .tick(dPixEn)
  );

  div_stage #(.W(DIV_W)) u_cpix (
    .clk(clk), .rst(rst), .ce(frac35En), .ratio(ctl.pixRatio), .tick(cPixEn)
  );

  assign pixEn = ctl.cphy ? cPixEn : dPixEn;
endmodule

// File: rtl/clk_div_tree.sv
module clk_div_tree
  import clk_tree_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              bitEn,
  output logic              byteEn,
  output logic              pixEn,
  output logic              phyModeC,
  output logic [DATA_W-1:0] ctrlModeCode,
  output logic              misCfg
);
  tree_ctl_t ctl;
  logic      frac35En;

  clk_tree_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .ctl(ctl),
    .ctrlModeCode(ctrlModeCode), .misCfg(misCfg)
  );

  clk_tree_dp u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .bitEn(bitEn), .byteEn(byteEn),
    .pixEn(pixEn), .frac35En(frac35En)
  );

  assign phyModeC = ctl.cphy;
endmodule

// File: rtl/clk_div_tree_chk.sv
module clk_div_tree_chk
  import clk_tree_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              bitEn,
  input logic              byteEn,
  input logic              pixEn,
  input logic              phyModeC,
  input logic              misCfg,
  input logic              frac35En
);
  logic rstD = 1'b0;
  always_ff @(posedge clk) rstD <= rst;

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    rstD |-> (bitEn && pixEn && !phyModeC && !misCfg));

  // R2
  mode_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr == 2'd0) |=> (phyModeC == $past(wrData[MODE_BIT])));

  // R4
  byte_in_bit_chk: assert property (@(posedge clk) disable iff (rst)
    byteEn |-> bitEn);

  // R6
  frac_gap_chk: assert property (@(posedge clk) disable iff (rst)
    frac35En |=> !frac35En);

  // R6
  cphy_pix_src_chk: assert property (@(posedge clk) disable iff (rst)
    (phyModeC && pixEn) |-> frac35En);

  // R7
  miscfg_cphy_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr == 2'd1 && phyModeC && wrData[1:0] != 2'd3) |=> misCfg);

  // R7
  miscfg_dphy_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr == 2'd1 && !phyModeC && wrData[1:0] == 2'd3) |=> misCfg);
endmodule

bind clk_div_tree clk_div_tree_chk u_chk (.*);

// File: tb/tb_clk_div_tree.sv
`timescale 1ns/1ps
module tb_clk_div_tree;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       bitEn, byteEn, pixEn, phyModeC, misCfg;
  logic [7:0] ctrlModeCode;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  clk_div_tree dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .bitEn(bitEn), .byteEn(byteEn),
    .pixEn(pixEn), .phyModeC(phyModeC), .ctrlModeCode(ctrlModeCode),
    .misCfg(misCfg)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wrEn = 1'b1; wrAddr = 2'(a); wrData = 8'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    rdAddr = 2'(a);
    #0.5;
    d = int'(rdData);
  endtask

  task automatic countSig(input int which, input int cyc, output int n);
    n = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      case (which)
        0: n += int'(bitEn);
        1: n += int'(byteEn);
        default: n += int'(pixEn);
      endcase
    end
  endtask

  task automatic settle();
    repeat (300) @(negedge clk);
  endtask

  task automatic testReset();
    int n, d;
    countSig(0, 40, n); check("R1 bitEn after reset", n, 40);
    countSig(2, 40, n); check("R1 pixEn after reset", n, 40);
    countSig(1, 80, n); check("R1 byteEn after reset", n, 10);
    check("R1 code", int'(ctrlModeCode), 16);
    check("R1 misCfg", int'(misCfg), 0);
    rd(2, d); check("R1 bit divider readback", d, 1);
    rd(1, d); check("R1 select readback", d, 0);
  endtask

  task automatic testDphyPaths();
    int n;
    wr(2, 3); wr(3, 2); settle();
    countSig(0, 120, n); check("R3 bitEn div3", n, 40);
    countSig(1, 240, n); check("R4 byteEn dphy div3x8", n, 10);
    countSig(2, 120, n); check("R5 pix sel0 div2", n, 20);
    wr(1, 1); wr(3, 5); settle();
    countSig(2, 300, n); check("R5 pix sel1 div5", n, 10);
    wr(1, 2); wr(3, 3); settle();
    countSig(2, 300, n); check("R5 pix sel2 div3", n, 25);
    check("R7 misCfg sel2 dphy", int'(misCfg), 0);
  endtask

  task automatic testBitEdges();
    int n;
    wr(2, 0); settle();
    countSig(0, 50, n); check("R3 bit divider zero acts as one", n, 50);
    wr(2, 15); settle();
    countSig(0, 150, n); check("R3 bit divider 15", n, 10);
  endtask

  task automatic testDeferred();
    int g1, g2;
    wr(2, 5); settle();
    while (bitEn !== 1'b1) @(negedge clk);
    wr(2, 2);
    g1 = 1;
    do begin @(negedge clk); g1++; end while (bitEn !== 1'b1);
    g2 = 0;
    do begin @(negedge clk); g2++; end while (bitEn !== 1'b1);
    check("R8 gap completing old ratio", g1, 5);
    check("R8 gap with new ratio", g2, 2);
  endtask

  task automatic testPixEdges();
    int n;
    wr(1, 0); wr(2, 1); wr(3, 15); settle();
    countSig(2, 150, n); check("R9 pix divider 15", n, 10);
    wr(3, 0); settle();
    countSig(2, 40, n); check("R9 pix divider zero acts as one", n, 40);
  endtask

  task automatic testCphy();
    int n, d, g1, g2;
    wr(1, 3); wr(0, 8'h40); wr(2, 2); wr(3, 1);
    check("R2 mode flag", int'(phyModeC), 1);
    check("R2 code cphy", int'(ctrlModeCode), 0);
    settle();
    rd(1, d); check("R6 select forced to 3", d, 3);
    countSig(1, 280, n); check("R4 byteEn cphy div2x7", n, 20);
    countSig(2, 70, n); check("R6 pix 3.5 div1", n, 20);
    while (pixEn !== 1'b1) @(negedge clk);
    g1 = 0;
    do begin @(negedge clk); g1++; end while (pixEn !== 1'b1);
    g2 = 0;
    do begin @(negedge clk); g2++; end while (pixEn !== 1'b1);
    check("R6 gap pair sums to 7", g1 + g2, 7);
    check("R6 gap is 3 or 4", int'(g1 == 3 || g1 == 4), 1);
    wr(3, 2); settle();
    countSig(2, 70, n); check("R6 pix 3.5 div2", n, 10);
    wr(3, 1); settle();
    wr(1, 1);
    check("R7 misCfg cphy sel1", int'(misCfg), 1);
    rd(1, d); check("R6 select stays 3 after write of 1", d, 3);
    countSig(2, 70, n); check("R6 pix rate unaffected by select", n, 20);
    wr(1, 3);
    check("R7 misCfg cleared sel3 cphy", int'(misCfg), 0);
  endtask

  task automatic testBackToDphy();
    int d;
    wr(0, 0);
    check("R2 mode back to dphy", int'(phyModeC), 0);
    check("R2 code dphy", int'(ctrlModeCode), 16);
    check("R7 misCfg dphy sel3", int'(misCfg), 1);
    rd(1, d); check("R7 sel3 accepted in dphy", d, 3);
    wr(1, 0);
    check("R7 misCfg cleared dphy sel0", int'(misCfg), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    testReset();
    testDphyPaths();
    testBitEdges();
    testDeferred();
    testPixEdges();
    testCphy();
    testBackToDphy();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule